// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns characters handed over by a processor into asynchronous serial frames on a single output line. Each frame starts with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, and one or more high stop bits close the frame. The character length, the parity mode, the stop length and the bit period are all set from configuration pins. The bit period is counted in ticks of an external transmit clock enable. Two characters can be in flight at once: one waits in a holding buffer while the other is shifted out.

Characters enter through a valid/ready stream port. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. `in_valid` may be held high across any number of cycles where `in_ready` is low, and the data must stay stable during that wait. `in_ready` also serves as the transmitter-ready indication. It is high only when transmission is enabled, the active-low clear-to-send input is asserted and the holding buffer is empty. A separate empty flag reports when nothing at all remains to send. A break input forces the line low. The configuration pins must stay stable while `tx_empty` is low.

Top module: `ser_async_tx`

## Requirements
- R1: Each frame is one low start bit, then the data bits least significant first, then the optional parity bit, then high stop bits. `cfg_len` codes 0, 1, 2, 3 select 5, 6, 7, 8 data bits.
- R2: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd`=0 the ones in the data bits plus parity are even in number, and with `cfg_par_odd`=1 they are odd. When `cfg_par_en` is 0, no parity bit is sent.
- R3: Every start, data and parity bit lasts 1, 16 or 64 ticks for `cfg_factor` codes 0, 1, 2 (code 3 also gives 64). Only cycles with `tick_en` high count as ticks, and `txd` changes only on such cycles unless `brk` changes.
- R4: `cfg_stop` code 0 gives one stop bit and codes 2 and 3 give two. Code 1 gives one and a half stop bits: 24 ticks in the 16-tick mode and 96 ticks in the 64-tick mode. In the 1-tick mode code 1 gives two stop bits.
- R5: `in_ready` is high exactly when `tx_en` is 1, `cts_n` is 0 and the holding buffer is empty.
- R6: After an accepted write, `in_ready` is low in the next cycle. It stays low until the held character moves into the shifter.
- R7: `tx_empty` is high when no character is held and no frame is in progress. It is low in the cycle after an accepted write.
- R8: A character that is waiting when the previous stop period ends starts its start bit on the very next tick, so there is no idle gap.
- R9: While `brk` is 1, `txd` is 0.
- R10: Deasserting `cts_n` or clearing `tx_en` stops new writes only. Characters already accepted are still sent in full.
- R11: `txd` is 1 whenever no frame is active and `brk` is 0.
- R12: Data bits above the configured character length are ignored. They appear neither on the line nor in the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Transmit clock enable, one pulse per tick |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop | input | 2 | Stop length code |
| cfg_factor | input | 2 | Ticks per bit code |
| tx_en | input | 1 | Transmit enable |
| cts_n | input | 1 | Clear to send, active low |
| brk | input | 1 | Force the line low |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character, right-aligned |
| in_ready | output | 1 | Holding buffer can take a character (transmitter ready) |
| txd | output | 1 | Serial line |
| tx_empty | output | 1 | Nothing held and no frame active |

## Verification
The hardest state to reach from the ports is the hand-off at the end of a stop period. To get there, a second character must already sit in the holding buffer while the first is still shifting, and this has to happen for every stop length, including the fractional one. The bench writes two characters per configuration and sweeps every length, parity and stop code under all three tick factors. It records the line once per tick and compares it against a tick-by-tick waveform built arithmetically from the requirements, so a gap or a stretched stop shows up as a misaligned sample. A separate case drops clear-to-send and the enable after two characters have been accepted, and checks that both frames still come out whole.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  // mask of the active data bits for a length code (0..3 -> 5..8 bits)
  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] code);
    return {CHAR_W{1'b1}} >> (2'd3 - code);
  endfunction
endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold
  import ser_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_ok,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] data
);
  logic              full_q;
  logic [CHAR_W-1:0] data_q;

  assign in_ready = gate_ok & ~full_q;
  assign full     = full_q;
  assign data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_tx_timer.sv
module ser_tx_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ser_tx_framer.sv
module ser_tx_framer
  import ser_tx_pkg::*;
#(
  parameter int MID_FACTOR  = 16,
  parameter int HIGH_FACTOR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_factor,
  input  logic              hold_full,
  input  logic [CHAR_W-1:0] hold_data,
  output logic              take,
  output logic              line,
  output logic              idle
);
  localparam int CW = $clog2(2 * HIGH_FACTOR + 1);
  localparam logic [CW-1:0] T_ONE  = CW'(1);
  localparam logic [CW-1:0] T_MID  = CW'(MID_FACTOR);
  localparam logic [CW-1:0] T_HIGH = CW'(HIGH_FACTOR);

  tx_state_e         state_q;
  logic [CHAR_W-1:0] sr_q;
  logic [2:0]        idx_q;
  logic              par_q;
  logic [CW-1:0]     bit_len, stop_len, load_val;
  logic              load, t_exp, done, start_now, last_bit;
  logic [CHAR_W-1:0] masked;

  always_comb begin
    case (cfg_factor)
      2'd0:    bit_len = T_ONE;
      2'd1:    bit_len = T_MID;
      default: bit_len = T_HIGH;
    endcase
    case (cfg_stop)
      2'd0:    stop_len = bit_len;
      2'd1:    stop_len = (cfg_factor == 2'd0) ? (bit_len << 1)
                                               : (bit_len + (bit_len >> 1));
      default: stop_len = bit_len << 1;
    endcase
  end

  assign masked    = hold_data & len_mask(cfg_len);
  assign done      = t_exp && (state_q != ST_IDLE);
  assign last_bit  = (idx_q == (3'd4 + {1'b0, cfg_len}));
  assign start_now = tick && hold_full &&
                     ((state_q == ST_IDLE) || (state_q == ST_STOP && done));
  assign take      = start_now;
  assign idle      = (state_q == ST_IDLE);

  always_comb begin
    load     = start_now;
    load_val = bit_len - 1'b1;
    if (!start_now && done) begin
      case (state_q)
        ST_START: load = 1'b1;
        ST_DATA: begin
          load = 1'b1;
          if (last_bit && !cfg_par_en) load_val = stop_len - 1'b1;
        end
        ST_PAR: begin
          load     = 1'b1;
          load_val = stop_len - 1'b1;
        end
        default: load = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = sr_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sr_q    <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
    end else if (start_now) begin
      state_q <= ST_START;
      sr_q    <= masked;
      idx_q   <= '0;
      par_q   <= cfg_par_odd ? ~(^masked) : (^masked);
    end else if (done) begin
      case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          if (last_bit) state_q <= cfg_par_en ? ST_PAR : ST_STOP;
          else begin
            idx_q <= idx_q + 1'b1;
            sr_q  <= sr_q >> 1;
          end
        end
        ST_PAR:  state_q <= ST_STOP;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ser_tx_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (load),
    .load_val (load_val),
    .expire   (t_exp)
  );
endmodule

// File: rtl/ser_async_tx.sv
module ser_async_tx
  import ser_tx_pkg::*;
#(
  parameter int MID_FACTOR  = 16,
  parameter int HIGH_FACTOR = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  input  logic [1:0] cfg_factor,
  input  logic       tx_en,
  input  logic       cts_n,
  input  logic       brk,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       txd,
  output logic       tx_empty
);
  logic              hold_full, take, line, idle;
  logic [CHAR_W-1:0] hold_data;

  ser_tx_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_ok  (tx_en & ~cts_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  ser_tx_framer #(
    .MID_FACTOR  (MID_FACTOR),
    .HIGH_FACTOR (HIGH_FACTOR)
  ) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_en),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_stop    (cfg_stop),
    .cfg_factor  (cfg_factor),
    .hold_full   (hold_full),
    .hold_data   (hold_data),
    .take        (take),
    .line        (line),
    .idle        (idle)
  );

  assign txd      = line & ~brk;
  assign tx_empty = ~hold_full & idle;
endmodule

// File: rtl/ser_async_tx_chk.sv
module ser_async_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic tx_en,
  input logic cts_n,
  input logic brk,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic tx_empty
);
  p_ready_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (tx_en && !cts_n));

  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_empty_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !tx_empty);

  p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> txd);

  p_txd_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk && !$past(brk) && !$past(tick_en)) |-> $stable(txd));
endmodule

bind ser_async_tx ser_async_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .tx_en    (tx_en),
  .cts_n    (cts_n),
  .brk      (brk),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .txd      (txd),
  .tx_empty (tx_empty)
);

// File: tb/sim_ser_async_tx.sv
module sim_ser_async_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'd0;
  logic [1:0] cfg_factor = 2'd0;
  logic       tx_en = 1'b1;
  logic       cts_n = 1'b0;
  logic       brk = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, txd, tx_empty;

  int n_chk = 0;
  int n_bad = 0;
  int tick_div = 1;
  int cyc = 0;
  bit rec = 1'b0;
  bit obs[$];
  bit exp_q[$];

  always #5 clk = ~clk;

  ser_async_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
    .cfg_factor(cfg_factor), .tx_en(tx_en), .cts_n(cts_n), .brk(brk),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .txd(txd), .tx_empty(tx_empty)
  );

  // one line sample per tick, taken after the edge that used the tick
  always @(negedge clk) begin
    if (rec && tick_en) obs.push_back(txd);
    cyc = cyc + 1;
    tick_en = ((cyc % tick_div) == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int bit_ticks();
    return (cfg_factor == 2'd0) ? 1 : (cfg_factor == 2'd1) ? 16 : 64;
  endfunction

  function automatic int stop_ticks();
    int f = bit_ticks();
    if (cfg_stop == 2'd0) return f;
    if (cfg_stop == 2'd1) return (f == 1) ? 2 : (f * 3) / 2;
    return 2 * f;
  endfunction

  task automatic add_bits(input bit v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  task automatic add_frame(input logic [7:0] d);
    int f  = bit_ticks();
    int nb = 5 + cfg_len;
    bit p  = 1'b0;
    add_bits(1'b0, f);
    for (int i = 0; i < nb; i++) begin
      add_bits(d[i], f);
      p ^= d[i];
    end
    if (cfg_par_en) add_bits(cfg_par_odd ? ~p : p, f);
    add_bits(1'b1, stop_ticks());
  endtask

  // R6 R7: write one character and look at the flags right after acceptance
  task automatic push(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R6 ready low after write", in_ready, 0);
    chk(tx_empty == 1'b0, "R7 empty low after write", tx_empty, 0);
  endtask

  task automatic check_wave(input string tag);
    int k = -1;
    bit ok = 1'b1;
    int bad_i = 0;
    for (int i = 0; i < obs.size(); i++)
      if (k < 0 && obs[i] == 1'b0) k = i;
    if (k < 0) begin
      chk(1'b0, tag, 0, 1);
      return;
    end
    if (obs.size() < k + exp_q.size()) begin
      chk(1'b0, tag, obs.size() - k, exp_q.size());
      return;
    end
    for (int j = 0; j < exp_q.size(); j++)
      if (ok && obs[k + j] != exp_q[j]) begin
        ok = 1'b0;
        bad_i = j;
      end
    for (int j = k + exp_q.size(); j < obs.size(); j++)
      if (ok && obs[j] != 1'b1) begin
        ok = 1'b0;
        bad_i = j - k;
      end
    chk(ok, tag, ok ? 0 : bad_i, -1);
  endtask

  task automatic drain();
    while (!tx_empty) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // reset state, R11 and R5
    chk(txd == 1'b1, "R11 idle txd in reset", txd, 1);
    chk(tx_empty == 1'b1, "R7 empty in reset", tx_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R5 ready after reset", in_ready, 1);
    chk(txd == 1'b1, "R11 idle txd", txd, 1);
    cts_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R5 ready needs cts", in_ready, 0);
    cts_n = 1'b0;
    tx_en = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R5 ready needs enable", in_ready, 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R5 ready restored", in_ready, 1);

    // sweep: R1 R2 R3 R4 R8 R12 for every code combination
    for (int f = 0; f < 3; f++)
      for (int ln = 0; ln < 4; ln++)
        for (int pm = 0; pm < 3; pm++)
          for (int st = 0; st < 3; st++) begin
            logic [7:0] d1, d2;
            cfg_factor  = 2'(f);
            cfg_len     = 2'(ln);
            cfg_par_en  = (pm != 0);
            cfg_par_odd = (pm == 2);
            cfg_stop    = 2'(st);
            tick_div    = (f == 2) ? 1 : (f == 1) ? 2 : 3;
            d1 = 8'(8'hC5 + 37 * (f * 36 + ln * 9 + pm * 3 + st));
            d2 = ~d1 ^ 8'h5A;
            obs.delete();
            exp_q.delete();
            add_frame(d1);
            add_frame(d2);
            rec = 1'b1;
            push(d1);
            push(d2);
            drain();
            rec = 1'b0;
            check_wave($sformatf("R1 R2 R3 R4 R8 R12 wave f=%0d len=%0d par=%0d stop=%0d",
                                 f, ln, pm, st));
          end

    // R10: drop cts and enable after two characters are accepted
    cfg_factor = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    cfg_stop = 2'd0; tick_div = 1;
    obs.delete(); exp_q.delete();
    add_frame(8'h3C); add_frame(8'hA7);
    rec = 1'b1;
    push(8'h3C);
    push(8'hA7);
    cts_n = 1'b1;
    tx_en = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 no new writes", in_ready, 0);
    drain();
    rec = 1'b0;
    check_wave("R10 accepted characters finish");
    cts_n = 1'b0;
    tx_en = 1'b1;

    // R9: break forces the line low while idle and during a frame
    brk = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd == 1'b0, "R9 break idle", txd, 0);
    in_valid = 1'b1; in_data = 8'hFF;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(txd == 1'b0, "R9 break in frame", txd, 0);
    brk = 1'b0;
    drain();
    chk(txd == 1'b1, "R11 idle after break", txd, 1);
    chk(tx_empty == 1'b1, "R7 empty after drain", tx_empty, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule